// File: doc/BRIEF.md
# Burst Bus Controller with Wait States

This block is the master side of a 32-bit demultiplexed external memory bus. An internal agent hands it one access at a time: a byte address, a direction, a beat count of one to four, and the data width of the target region (8, 16 or 32 bits). The controller then runs the bus protocol. It strobes the address, counts out programmed wait states, and optionally stretches each data cycle until the external READY input arrives. It steps the address from beat to beat within an aligned 16-byte block and drives the data-transceiver enable and direction. The external side may break a burst with the burst-terminate input, and the controller then restarts the rest of it with a fresh address strobe.

The core is a five-state machine. IDLE (port ready) moves to ADDR on a request. ADDR (address strobe) moves to WAIT when the first-data count is non-zero, and to XFER otherwise. WAIT (internal wait states) moves to XFER when its count runs out. XFER (data cycle) completes a beat and then goes to ADDR after a burst-terminate, to WAIT or XFER for the next beat, to GAP when a recovery count is set, or to IDLE. GAP (inter-access recovery) moves to IDLE when its count runs out. Wait counts are live configuration inputs: separate first-beat and later-beat counts for reads and for writes, plus a recovery count. The byte-enable outputs change meaning with the region width.

Top module: `bbc_top`

## Requirements
- R1: `ads` is high for exactly one cycle at the start of each access, the cycle after a request is taken; `req_ready` is high only while the controller is idle, including during reset.
- R2: `bus_read` (1 = read) and `dt_rx` (1 = controller receiving) reflect the accepted request from its `ads` cycle on; `bus_read` changes only in an `ads` cycle and `dt_rx` never changes while `den` stays high.
- R3: Byte address of beat k+1 equals that of beat k plus the region width in bytes (1, 2 or 4), wrapping within bits 3:0; bits 31:4 never change inside an access. On a 32-bit region this makes word address bits 1:0 count up modulo 4.
- R4: A new access waits N cycles with `wait_st` high between `ads` and its data cycle, N being the read or write first-beat count; later beats of the same access use the later-beat count; a count of 0 gives no wait cycle.
- R5: With READY enabled, `ready_in` is sampled only in data cycles; while it is low the data cycle repeats with `wait_st` low. With READY disabled every data cycle completes at once (`beat_done`).
- R6: `blast` is high in every data cycle of the final beat, including READY-stretched ones, and in no other cycle.
- R7: With burst-terminate enabled, `bterm_in` high in a data cycle completes the beat even with `ready_in` low; if beats remain, the next cycle carries a new `ads` at the next beat address followed by the first-beat count. When disabled, `bterm_in` has no effect.
- R8: `den` is high in all WAIT and data cycles and low in `ads`, idle and recovery cycles.
- R9: On a 16-bit region (`req_width` = 1) `be` = {1, 0, address bit 1, 1}: bit 3 byte-high strobe, bit 1 address bit 1, bit 0 byte-low strobe.
- R10: On an 8-bit region (`req_width` = 0) `be` = {0, 0, address bit 1, address bit 0}.
- R11: After the last beat, the bus stays quiet for `cfg_gap` cycles with `req_ready` low and READY ignored, then returns to idle.
- R12: On a 32-bit region (`req_width` = 2) `be` = 4'b1111 and byte address bits 1:0 are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_addr | input | ADDR_W | Start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats | input | LEN_W | Number of beats minus one |
| req_width | input | 2 | Region width: 0 = 8, 1 = 16, 2 = 32 bits |
| cfg_rd_first | input | CNT_W | Read first-beat wait count |
| cfg_rd_next | input | CNT_W | Read later-beat wait count |
| cfg_wr_first | input | CNT_W | Write first-beat wait count |
| cfg_wr_next | input | CNT_W | Write later-beat wait count |
| cfg_gap | input | CNT_W | Recovery cycles after an access |
| cfg_ready_en | input | 1 | Data cycles wait for `ready_in` |
| cfg_bterm_en | input | 1 | `bterm_in` is honoured |
| ready_in | input | 1 | External ready |
| bterm_in | input | 1 | External burst terminate |
| ads | output | 1 | Address strobe |
| addr_word | output | ADDR_W-2 | Word address (byte address bits 31:2) |
| be | output | 4 | Byte enables, width-dependent encoding |
| bus_read | output | 1 | 1 = read access |
| dt_rx | output | 1 | Transceiver direction, 1 = receive |
| den | output | 1 | Transceiver enable |
| wait_st | output | 1 | Internal wait state in progress |
| blast | output | 1 | Final beat |
| beat_done | output | 1 | Data cycle completes this cycle |

## Verification
The hardest situation to reach is a burst-terminate on a middle beat. It comes while READY is held low, so the beat must finish through the terminate path alone, and the restart has to pick up both the stepped address and the first-beat wait count. The bench scripts READY stalls and terminate positions per beat and holds `ready_in` and `bterm_in` high throughout wait and recovery cycles, so any early sampling shows. A behavioural model in the bench predicts every output cycle by cycle, and one test asserts a terminate on the last beat to confirm that no new strobe follows.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_XFER,
        ST_GAP
    } bbc_state_e;

    typedef enum logic [1:0] {
        BW_8  = 2'd0,
        BW_16 = 2'd1,
        BW_32 = 2'd2
    } bbc_width_e;
endpackage

// File: rtl/bbc_lane_map.sv
module bbc_lane_map
    import bbc_pkg::*;
(
    input  bbc_width_e  width,
    input  logic [1:0]  byte_lo,
    output logic [3:0]  be
);
    always_comb begin
        unique case (width)
            BW_8:    be = {2'b00, byte_lo};
            BW_16:   be = {1'b1, 1'b0, byte_lo[1], 1'b1};
            default: be = 4'b1111;
        endcase
    end
endmodule

// File: rtl/bbc_beat_addr.sv
module bbc_beat_addr
    import bbc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  bbc_width_e        load_width,
    input  logic              step,
    input  bbc_width_e        width,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int BLK_W = 4;

    logic [BLK_W-1:0]  inc;
    logic [ADDR_W-1:0] aligned;

    always_comb begin
        unique case (width)
            BW_8:    inc = 4'd1;
            BW_16:   inc = 4'd2;
            default: inc = 4'd4;
        endcase
        unique case (load_width)
            BW_8:    aligned = load_addr;
            BW_16:   aligned = {load_addr[ADDR_W-1:1], 1'b0};
            default: aligned = {load_addr[ADDR_W-1:2], 2'b00};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= aligned;
        end else if (step) begin
            cur_addr <= {cur_addr[ADDR_W-1:BLK_W], cur_addr[BLK_W-1:0] + inc};
        end
    end

    // R3: stepping stays inside the aligned 16-byte block
    p_block_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_addr[ADDR_W-1:BLK_W] == $past(cur_addr[ADDR_W-1:BLK_W])));
endmodule

// File: rtl/bbc_top.sv
module bbc_top
    import bbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_beats,
    input  logic [1:0]        req_width,
    input  logic [CNT_W-1:0]  cfg_rd_first,
    input  logic [CNT_W-1:0]  cfg_rd_next,
    input  logic [CNT_W-1:0]  cfg_wr_first,
    input  logic [CNT_W-1:0]  cfg_wr_next,
    input  logic [CNT_W-1:0]  cfg_gap,
    input  logic              cfg_ready_en,
    input  logic              cfg_bterm_en,
    input  logic              ready_in,
    input  logic              bterm_in,
    output logic              ads,
    output logic [ADDR_W-3:0] addr_word,
    output logic [3:0]        be,
    output logic              bus_read,
    output logic              dt_rx,
    output logic              den,
    output logic              wait_st,
    output logic              blast,
    output logic              beat_done
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    bbc_state_e        state, state_d;
    logic [CNT_W-1:0]  cnt, cnt_d;
    logic [LEN_W-1:0]  left, left_d;
    logic              rd_q;
    bbc_width_e        width_q;
    logic              load;
    logic [CNT_W-1:0]  first_n, next_n;
    logic              bterm_hit, done_x, last, step;
    logic [ADDR_W-1:0] cur_addr;

    assign first_n   = rd_q ? cfg_rd_first : cfg_wr_first;
    assign next_n    = rd_q ? cfg_rd_next  : cfg_wr_next;
    assign bterm_hit = cfg_bterm_en & bterm_in;
    assign last      = (left == '0);
    assign done_x    = (state == ST_XFER) & (bterm_hit | ~cfg_ready_en | ready_in);
    assign step      = done_x & ~last;

    // next-state and counters
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        left_d  = left;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_ADDR;
                    load    = 1'b1;
                    left_d  = req_beats;
                end
            end
            ST_ADDR: begin
                if (first_n == '0) begin
                    state_d = ST_XFER;
                end else begin
                    state_d = ST_WAIT;
                    cnt_d   = first_n;
                end
            end
            ST_WAIT: begin
                cnt_d = cnt - CNT_ONE;
                if (cnt == CNT_ONE) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (done_x) begin
                    if (last) begin
                        if (cfg_gap == '0) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_GAP;
                            cnt_d   = cfg_gap;
                        end
                    end else begin
                        left_d = left - LEN_ONE;
                        if (bterm_hit) begin
                            state_d = ST_ADDR;
                        end else if (next_n == '0) begin
                            state_d = ST_XFER;
                        end else begin
                            state_d = ST_WAIT;
                            cnt_d   = next_n;
                        end
                    end
                end
            end
            ST_GAP: begin
                cnt_d = cnt - CNT_ONE;
                if (cnt == CNT_ONE) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            left    <= '0;
            rd_q    <= 1'b1;
            width_q <= BW_32;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            left  <= left_d;
            if (load) begin
                rd_q    <= ~req_write;
                width_q <= bbc_width_e'(req_width);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        ads       = (state == ST_ADDR);
        wait_st   = (state == ST_WAIT);
        den       = (state == ST_WAIT) || (state == ST_XFER);
        blast     = (state == ST_XFER) && last;
        beat_done = done_x;
        bus_read  = rd_q;
        dt_rx     = rd_q;
    end

    bbc_beat_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (req_addr),
        .load_width (bbc_width_e'(req_width)),
        .step       (step),
        .width      (width_q),
        .cur_addr   (cur_addr)
    );

    assign addr_word = cur_addr[ADDR_W-1:2];

    bbc_lane_map u_lanes (
        .width   (width_q),
        .byte_lo (cur_addr[1:0]),
        .be      (be)
    );

    p_ads_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ads |=> !ads);
    p_dir_with_ads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_read) |-> ads);
    p_dt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (den && $past(den)) |-> $stable(dt_rx));
    p_done_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> (den && !wait_st));
    p_wait_noblast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wait_st |-> !blast);
    p_blast_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blast && !beat_done) |=> blast);
    p_bterm_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && bterm_hit && !blast) |=> ads);
    p_den_off_ads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ads |-> !den);
endmodule

// File: tb/tb_bbc_top.sv
module tb_bbc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_beats = '0;
    logic [1:0]  req_width = 2'd2;
    logic [3:0]  cfg_rd_first = '0, cfg_rd_next = '0;
    logic [3:0]  cfg_wr_first = '0, cfg_wr_next = '0;
    logic [3:0]  cfg_gap = '0;
    logic        cfg_ready_en = 1'b0, cfg_bterm_en = 1'b0;
    logic        ready_in = 1'b0, bterm_in = 1'b0;
    logic        ads, bus_read, dt_rx, den, wait_st, blast, beat_done;
    logic [29:0] addr_word;
    logic [3:0]  be;

    int n_chk = 0;
    int n_fail = 0;
    logic bterm_noise = 1'b0;

    always #4 clk = ~clk;

    bbc_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_beats(req_beats),
        .req_width(req_width), .cfg_rd_first(cfg_rd_first), .cfg_rd_next(cfg_rd_next),
        .cfg_wr_first(cfg_wr_first), .cfg_wr_next(cfg_wr_next), .cfg_gap(cfg_gap),
        .cfg_ready_en(cfg_ready_en), .cfg_bterm_en(cfg_bterm_en),
        .ready_in(ready_in), .bterm_in(bterm_in), .ads(ads), .addr_word(addr_word),
        .be(be), .bus_read(bus_read), .dt_rx(dt_rx), .den(den), .wait_st(wait_st),
        .blast(blast), .beat_done(beat_done)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input int w, input logic [31:0] a);
        case (w)
            0:       return {2'b00, a[1:0]};                  // R10
            1:       return {1'b1, 1'b0, a[1], 1'b1};         // R9
            default: return 4'b1111;                          // R12
        endcase
    endfunction

    function automatic string be_tag(input int w);
        case (w)
            0:       return "R10";
            1:       return "R9";
            default: return "R12";
        endcase
    endfunction

    // compare every output of one cycle against the model's expectation
    task automatic cmp(input logic e_ads, input logic e_wait, input logic e_den,
                       input logic e_blast, input logic e_done, input logic e_rdy,
                       input logic e_rd, input int w, input logic [31:0] a,
                       input logic cmp_addr, input string ads_tag);
        chk(ads == e_ads, ads_tag, 32'(ads), 32'(e_ads));
        chk(req_ready == e_rdy, e_rdy ? "R1" : "R11", 32'(req_ready), 32'(e_rdy));
        chk(wait_st == e_wait, "R4", 32'(wait_st), 32'(e_wait));
        chk(den == e_den, "R8", 32'(den), 32'(e_den));
        chk(blast == e_blast, "R6", 32'(blast), 32'(e_blast));
        chk(beat_done == e_done, "R5", 32'(beat_done), 32'(e_done));
        if (cmp_addr) begin
            chk(bus_read == e_rd, "R2", 32'(bus_read), 32'(e_rd));
            chk(dt_rx == e_rd, "R2", 32'(dt_rx), 32'(e_rd));
            chk(addr_word == a[31:2], "R3", 32'(addr_word), 32'(a[31:2]));
            chk(be == exp_be(w, a), be_tag(w), 32'(be), 32'(exp_be(w, a)));
        end
    endtask

    task automatic access(input logic [31:0] addr, input logic wr, input int beats,
                          input int w, input int st [4], input logic bt [4]);
        logic [31:0] a;
        logic        rd;
        int          n;
        logic        fin;
        int          inc;
        rd  = !wr;
        inc = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        a   = (w == 0) ? addr : (w == 1) ? {addr[31:1], 1'b0} : {addr[31:2], 2'b00};
        @(negedge clk);
        ready_in = 1'b0; bterm_in = 1'b0;
        chk(req_ready == 1'b1, "R1", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = addr; req_write = wr;
        req_beats = 2'(beats - 1); req_width = 2'(w);
        for (int b = 0; b < beats; b++) begin
            logic newacc;
            newacc = (b == 0) || bt[b-1];
            if (newacc) begin
                @(negedge clk);
                req_valid = 1'b0; ready_in = 1'b0; bterm_in = 1'b0;
                #1 cmp(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rd, w, a, 1'b1,
                       (b > 0) ? "R7" : "R1");
                n = rd ? int'(cfg_rd_first) : int'(cfg_wr_first);
            end else begin
                n = rd ? int'(cfg_rd_next) : int'(cfg_wr_next);
            end
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                ready_in = 1'b1; bterm_in = 1'b1;   // must not be sampled here
                #1 cmp(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, rd, w, a, 1'b1, "R1");
            end
            for (int j = 0; j <= st[b]; j++) begin
                @(negedge clk);
                fin = (j == st[b]);
                if (bt[b] && fin) begin
                    bterm_in = 1'b1; ready_in = 1'b0;   // R7: ready ignored
                end else begin
                    bterm_in = bterm_noise;
                    ready_in = cfg_ready_en ? fin : 1'b0;
                end
                #1 cmp(1'b0, 1'b0, 1'b1, (b == beats - 1), fin, 1'b0, rd, w, a, 1'b1, "R1");
            end
            a = {a[31:4], 4'(a[3:0] + 4'(inc))};
        end
        for (int g = 0; g < int'(cfg_gap); g++) begin
            @(negedge clk);
            ready_in = 1'b1; bterm_in = 1'b1;
            #1 cmp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rd, w, a, 1'b0, "R1");
        end
        @(negedge clk);
        ready_in = 1'b0; bterm_in = 1'b0;
        #1 cmp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, rd, w, a, 1'b0, "R11");
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R1 and R8
        cmp(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 32'h0, 1'b0, "R1");
        rst_n = 1'b1;

        // 32-bit read burst, internal waits only (R4, R3, R12)
        cfg_rd_first = 4'd2; cfg_rd_next = 4'd1; cfg_ready_en = 1'b0; cfg_gap = 4'd0;
        access(32'h1000_0000, 1'b0, 4, 2, '{0, 0, 0, 0}, '{0, 0, 0, 0});

        // 32-bit write, READY stalls, address wraps in block, recovery (R5, R11, R3)
        cfg_wr_first = 4'd0; cfg_wr_next = 4'd0; cfg_ready_en = 1'b1; cfg_gap = 4'd2;
        access(32'h2000_0048, 1'b1, 3, 2, '{2, 0, 1, 0}, '{0, 0, 0, 0});

        // 16-bit read burst (R9)
        cfg_rd_first = 4'd1; cfg_rd_next = 4'd0; cfg_gap = 4'd1;
        access(32'h3000_000A, 1'b0, 4, 1, '{0, 1, 0, 0}, '{0, 0, 0, 0});

        // 8-bit write burst crossing block wrap (R10)
        cfg_wr_first = 4'd1; cfg_wr_next = 4'd2; cfg_ready_en = 1'b0; cfg_gap = 4'd0;
        access(32'h4000_001E, 1'b1, 4, 0, '{0, 0, 0, 0}, '{0, 0, 0, 0});

        // burst terminate mid-burst and on last beat (R7)
        cfg_bterm_en = 1'b1; cfg_ready_en = 1'b1;
        cfg_rd_first = 4'd2; cfg_rd_next = 4'd1; cfg_gap = 4'd1;
        access(32'h5000_0004, 1'b0, 4, 2, '{0, 1, 0, 0}, '{0, 1, 0, 1});

        // terminate disabled: bterm_in held high during stalls has no effect (R7)
        cfg_bterm_en = 1'b0; bterm_noise = 1'b1; cfg_gap = 4'd0;
        cfg_wr_first = 4'd0; cfg_wr_next = 4'd0;
        access(32'h6000_0010, 1'b1, 2, 2, '{3, 1, 0, 0}, '{0, 0, 0, 0});
        bterm_noise = 1'b0;

        // single byte read, zero waits, long recovery (R4, R11)
        cfg_rd_first = 4'd0; cfg_ready_en = 1'b0; cfg_gap = 4'd3;
        access(32'h7000_0003, 1'b0, 1, 0, '{0, 0, 0, 0}, '{0, 0, 0, 0});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule